// File: doc/BRIEF.md
# Ethernet MAC Clock Bring-Up Sequencer

This block brings up the clock of one of two Ethernet MACs when asked. A one-cycle request carries a MAC index. The block reads a per-MAC strap that marks gigabit (RGMII) wiring and picks a target rate of 100 MHz or 25 MHz. It divides the static source PLL rate by that target and clamps the quotient to the range the divider supports. The result is encoded into a divider select field.

It then runs a timed bring-up of the chosen MAC. The MAC is put into reset and, after a short wait, its clock gate is opened. After a long wait the reset is released. A write-unlock output stays high for the whole run. At the end the block pulses done and reports the rate it chose. The waits are counted in reference-clock cycles, using a cycles-per-microsecond parameter.

Top module: `macclk_seq`

## Requirements
- R1: The chosen rate is 100 MHz when either strap bit is 1 and 25 MHz when both are 0. It appears on `rate_mhz_o` from acceptance of the request and is held until the next accepted request.
- R2: The divisor is the integer quotient of `src_mhz_i` divided by the chosen rate. `div_field_o` is (divisor − 2) / 2, with the fraction dropped.
- R3: A quotient below 4 is replaced by 4, and one above 16 by 16. `clamp_o` is 1 exactly when one of these replacements was made.
- R4: A request with `mac_sel_i` equal to 0 or 3 raises `err_o` for one cycle. It leaves `busy_o` low and changes no other output.
- R5: Index 1 selects bit 0 and index 2 selects bit 1 of `mac_rst_o` and `clk_stop_o`. In the first cycle after an accepted request, that MAC's `mac_rst_o` bit goes to 1. Exactly CYC_PER_US×RST_WAIT_US cycles later, its `clk_stop_o` bit goes to 0.
- R6: Exactly CYC_PER_US×CLK_WAIT_US cycles after the clock gate opens, the MAC's reset bit returns to 0. In that same cycle `done_o` is high, for one cycle only.
- R7: `unlock_o` is 1 exactly while `busy_o` is 1, from acceptance until done.
- R8: A request that arrives while `busy_o` is 1 is ignored.
- R9: The bits of the MAC not being brought up never change. All outputs stay unchanged while the block is idle.
- R10: After reset, `mac_rst_o`=00, `clk_stop_o`=11, `div_field_o`=0, and `busy_o`, `unlock_o`, `done_o`, `err_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Bring-up request, one cycle |
| mac_sel_i | input | 2 | MAC index (1 or 2 valid) |
| strap_gbe_i | input | 2 | Per-MAC gigabit strap |
| src_mhz_i | input | RATE_W | Source PLL rate in MHz |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | Sequence finished, one-cycle pulse |
| err_o | output | 1 | Invalid index rejected, one-cycle pulse |
| clamp_o | output | 1 | Divisor was clamped |
| rate_mhz_o | output | 7 | Chosen MAC clock rate in MHz |
| div_field_o | output | FIELD_W | Encoded divider select |
| mac_rst_o | output | 2 | Per-MAC reset |
| clk_stop_o | output | 2 | Per-MAC clock stop |
| unlock_o | output | 1 | Register write unlock |

## Verification
The bench builds the block with CYC_PER_US=2, RST_WAIT_US=3 and CLK_WAIT_US=5. This turns the 100 µs and 10 ms waits into 6 and 10 cycles. Many complete bring-ups therefore fit in a short run, and the exact cycle count of both intervals can be checked. The source rates are chosen to hit both clamp limits, an odd unclamped divisor and both straps. The run also includes invalid indices and a request that arrives mid-sequence.

// File: rtl/macclk_pkg.sv
package macclk_pkg;
  localparam int RATE_GBE_MHZ = 100;
  localparam int RATE_FE_MHZ  = 25;
  localparam int DIV_MIN      = 4;
  localparam int DIV_MAX      = 16;
  localparam int DIV_W        = $clog2(DIV_MAX + 1);
  localparam int FIELD_W      = $clog2((DIV_MAX - 2) / 2 + 1);

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_HOLD,
    ST_UNGATE
  } seq_st_e;
endpackage

// File: rtl/macclk_rate_calc.sv
module macclk_rate_calc
  import macclk_pkg::*;
#(
  parameter int RATE_W = 12
) (
  input  logic [1:0]         strap_i,
  input  logic [RATE_W-1:0]  src_mhz_i,
  output logic [6:0]         rate_mhz_o,
  output logic [FIELD_W-1:0] field_o,
  output logic               clamp_o
);
  logic              gbe;
  logic [RATE_W-1:0] quot;
  logic [DIV_W-1:0]  div;

  always_comb begin
    gbe        = |strap_i;
    rate_mhz_o = gbe ? 7'(RATE_GBE_MHZ) : 7'(RATE_FE_MHZ);
    quot       = gbe ? src_mhz_i / RATE_W'(RATE_GBE_MHZ)
                     : src_mhz_i / RATE_W'(RATE_FE_MHZ);
    clamp_o    = 1'b0;
    if (quot < RATE_W'(DIV_MIN)) begin
      div     = DIV_W'(DIV_MIN);
      clamp_o = 1'b1;
    end else if (quot > RATE_W'(DIV_MAX)) begin
      div     = DIV_W'(DIV_MAX);
      clamp_o = 1'b1;
    end else begin
      div = DIV_W'(quot);
    end
    field_o = FIELD_W'((div - DIV_W'(2)) >> 1);
  end
endmodule

// File: rtl/macclk_timer.sv
module macclk_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic             expired_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (load_i)        cnt_q <= load_val_i;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign expired_o = (cnt_q == '0);

  // R5 / R6: wait intervals rely on a strict one-per-cycle countdown
  a_r5_count_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));
  a_r6_rest_at_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && cnt_q == '0) |=> (cnt_q == '0));
endmodule

// File: rtl/macclk_seq.sv
module macclk_seq
  import macclk_pkg::*;
#(
  parameter int RATE_W      = 12,
  parameter int CYC_PER_US  = 250,
  parameter int RST_WAIT_US = 100,
  parameter int CLK_WAIT_US = 10000
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               req_i,
  input  logic [1:0]         mac_sel_i,
  input  logic [1:0]         strap_gbe_i,
  input  logic [RATE_W-1:0]  src_mhz_i,
  output logic               busy_o,
  output logic               done_o,
  output logic               err_o,
  output logic               clamp_o,
  output logic [6:0]         rate_mhz_o,
  output logic [FIELD_W-1:0] div_field_o,
  output logic [1:0]         mac_rst_o,
  output logic [1:0]         clk_stop_o,
  output logic               unlock_o
);
  localparam int HOLD_CYC   = CYC_PER_US * RST_WAIT_US;
  localparam int UNGATE_CYC = CYC_PER_US * CLK_WAIT_US;
  localparam int MAX_CYC    = (HOLD_CYC > UNGATE_CYC) ? HOLD_CYC : UNGATE_CYC;
  localparam int CNT_W      = $clog2(MAX_CYC + 1);

  seq_st_e            st_q;
  logic               cur_q;
  logic               idx_ok, accept, expired, tmr_load;
  logic [CNT_W-1:0]   tmr_val;
  logic [6:0]         calc_rate;
  logic [FIELD_W-1:0] calc_field;
  logic               calc_clamp;

  macclk_rate_calc #(.RATE_W(RATE_W)) u_calc (
    .strap_i    (strap_gbe_i),
    .src_mhz_i  (src_mhz_i),
    .rate_mhz_o (calc_rate),
    .field_o    (calc_field),
    .clamp_o    (calc_clamp)
  );

  assign idx_ok = (mac_sel_i == 2'd1) || (mac_sel_i == 2'd2);
  assign accept = (st_q == ST_IDLE) && req_i && idx_ok;

  always_comb begin
    tmr_load = 1'b0;
    tmr_val  = '0;
    if (accept) begin
      tmr_load = 1'b1;
      tmr_val  = CNT_W'(HOLD_CYC - 1);
    end else if (st_q == ST_HOLD && expired) begin
      tmr_load = 1'b1;
      tmr_val  = CNT_W'(UNGATE_CYC - 1);
    end
  end

  macclk_timer #(.CNT_W(CNT_W)) u_timer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (tmr_load),
    .load_val_i (tmr_val),
    .expired_o  (expired)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q        <= ST_IDLE;
      cur_q       <= 1'b0;
      done_o      <= 1'b0;
      err_o       <= 1'b0;
      clamp_o     <= 1'b0;
      rate_mhz_o  <= '0;
      div_field_o <= '0;
      mac_rst_o   <= 2'b00;
      clk_stop_o  <= 2'b11;
      unlock_o    <= 1'b0;
    end else begin
      done_o <= 1'b0;
      err_o  <= 1'b0;
      unique case (st_q)
        ST_IDLE: if (req_i) begin
          if (idx_ok) begin
            cur_q                  <= mac_sel_i[1];
            mac_rst_o[mac_sel_i[1]] <= 1'b1;
            rate_mhz_o             <= calc_rate;
            div_field_o            <= calc_field;
            clamp_o                <= calc_clamp;
            unlock_o               <= 1'b1;
            st_q                   <= ST_HOLD;
          end else begin
            err_o <= 1'b1;
          end
        end
        ST_HOLD: if (expired) begin
          clk_stop_o[cur_q] <= 1'b0;
          st_q              <= ST_UNGATE;
        end
        ST_UNGATE: if (expired) begin
          mac_rst_o[cur_q] <= 1'b0;
          done_o           <= 1'b1;
          unlock_o         <= 1'b0;
          st_q             <= ST_IDLE;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o = (st_q != ST_IDLE);

  a_r7_unlock_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    unlock_o == busy_o);
  a_r4_err_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> !busy_o);
  a_r6_done_ends_run: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!busy_o && $past(busy_o)));
  a_r9_idle_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && $past(!busy_o)) |->
      ($stable(mac_rst_o) && $stable(clk_stop_o) && $stable(div_field_o)));
  a_r3_clamp_edge: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clamp_o |-> (div_field_o == FIELD_W'(1) || div_field_o == FIELD_W'((DIV_MAX - 2) / 2)));

  for (genvar g = 0; g < 2; g++) begin : g_mac_chk
    a_r5_ungate_in_reset: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(clk_stop_o[g]) |-> mac_rst_o[g]);
    a_r6_release_ungated: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(mac_rst_o[g]) |-> (!clk_stop_o[g] && done_o));
  end
endmodule

// File: tb/macclk_seq_test.sv
module macclk_seq_test;
  localparam int N_HOLD   = 6;
  localparam int N_UNGATE = 10;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_i = 1'b0;
  logic [1:0]  mac_sel_i = '0;
  logic [1:0]  strap_gbe_i = '0;
  logic [11:0] src_mhz_i = '0;
  logic        busy_o, done_o, err_o, clamp_o, unlock_o;
  logic [6:0]  rate_mhz_o;
  logic [2:0]  div_field_o;
  logic [1:0]  mac_rst_o, clk_stop_o;

  macclk_seq #(.RATE_W(12), .CYC_PER_US(2), .RST_WAIT_US(3), .CLK_WAIT_US(5)) uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .mac_sel_i(mac_sel_i),
    .strap_gbe_i(strap_gbe_i), .src_mhz_i(src_mhz_i), .busy_o(busy_o),
    .done_o(done_o), .err_o(err_o), .clamp_o(clamp_o), .rate_mhz_o(rate_mhz_o),
    .div_field_o(div_field_o), .mac_rst_o(mac_rst_o), .clk_stop_o(clk_stop_o),
    .unlock_o(unlock_o)
  );

  always #2 clk_i = ~clk_i;

  typedef struct {
    bit       is_err;
    int       mac;
    int       rate;
    int       field;
    bit       clamp;
    bit [1:0] rst;
    bit [1:0] stop;
  } exp_t;

  exp_t     sb[$];
  int       total = 0, bad = 0, cyc = 0;
  bit [1:0] m_rst = 2'b00, m_stop = 2'b11;
  int       last_field = 0;
  bit       finished = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic bringup(input int mac, input bit [1:0] strap, input int src, input bit inject);
    exp_t e;
    int   q;
    e.is_err = 0;
    e.mac    = mac - 1;
    e.rate   = (strap != 0) ? 100 : 25;
    q        = src / e.rate;
    e.clamp  = (q < 4) || (q > 16);
    if (q < 4) q = 4;
    if (q > 16) q = 16;
    e.field  = (q - 2) / 2;
    m_rst[mac-1]  = 0;
    m_stop[mac-1] = 0;
    e.rst  = m_rst;
    e.stop = m_stop;
    last_field = e.field;
    sb.push_back(e);
    @(negedge clk_i);
    req_i = 1; mac_sel_i = 2'(mac); strap_gbe_i = strap; src_mhz_i = 12'(src);
    @(negedge clk_i);
    req_i = 0;
    if (inject) begin
      repeat (2) @(negedge clk_i);
      req_i = 1; mac_sel_i = 2'(3 - mac); // R8: ignored while busy
      @(negedge clk_i);
      req_i = 0; mac_sel_i = 2'(mac);
    end
    while (busy_o) @(negedge clk_i);
    repeat (3) @(negedge clk_i);
    // R9: outputs hold after the run
    check(mac_rst_o == m_rst, "R9 rst hold", mac_rst_o, m_rst);
    check(clk_stop_o == m_stop, "R9 stop hold", clk_stop_o, m_stop);
    check(div_field_o == 3'(e.field), "R9 field hold", div_field_o, e.field);
  endtask

  task automatic bad_index(input int idx);
    exp_t e;
    e.is_err = 1; e.mac = 0; e.rate = 0; e.clamp = 0;
    e.field = last_field; e.rst = m_rst; e.stop = m_stop;
    sb.push_back(e);
    @(negedge clk_i);
    req_i = 1; mac_sel_i = 2'(idx);
    @(negedge clk_i);
    req_i = 0;
    repeat (3) @(negedge clk_i);
  endtask

  // monitor
  initial begin
    bit [1:0] p_rst = 2'b00, p_stop = 2'b11;
    bit       p_done = 0;
    int       t_rst[2], t_clk[2];
    exp_t     e;
    forever begin
      @(negedge clk_i);
      cyc++;
      if (rst_ni) begin
        for (int m = 0; m < 2; m++) begin
          if (mac_rst_o[m] && !p_rst[m]) t_rst[m] = cyc;
          if (!clk_stop_o[m] && p_stop[m]) begin
            t_clk[m] = cyc;
            check(cyc - t_rst[m] == N_HOLD, "R5 ungate delay", cyc - t_rst[m], N_HOLD);
            check(unlock_o && busy_o, "R7 unlock mid-run", unlock_o, 1);
          end
        end
        if (done_o && p_done) check(0, "R6 done width", 2, 1);
        if (done_o) begin
          if (sb.size() == 0) check(0, "R6 unexpected done", 1, 0);
          else begin
            e = sb.pop_front();
            check(!e.is_err, "R6 done vs err", 1, 0);
            check(rate_mhz_o == 7'(e.rate), "R1 rate", rate_mhz_o, e.rate);
            check(div_field_o == 3'(e.field), "R2 field", div_field_o, e.field);
            check(clamp_o == e.clamp, "R3 clamp", clamp_o, e.clamp);
            check(mac_rst_o == e.rst, "R8 rst bits", mac_rst_o, e.rst);
            check(clk_stop_o == e.stop, "R8 stop bits", clk_stop_o, e.stop);
            check(cyc - t_rst[e.mac] == N_HOLD + N_UNGATE, "R6 release delay",
                  cyc - t_rst[e.mac], N_HOLD + N_UNGATE);
            check(!unlock_o, "R7 unlock at done", unlock_o, 0);
          end
        end
        if (err_o) begin
          if (sb.size() == 0) check(0, "R4 unexpected err", 1, 0);
          else begin
            e = sb.pop_front();
            check(e.is_err, "R4 err flag", 0, 1);
            check(!busy_o, "R4 busy", busy_o, 0);
            check(mac_rst_o == e.rst, "R4 rst unchanged", mac_rst_o, e.rst);
            check(clk_stop_o == e.stop, "R4 stop unchanged", clk_stop_o, e.stop);
            check(div_field_o == 3'(e.field), "R4 field unchanged", div_field_o, e.field);
          end
        end
      end
      p_rst = mac_rst_o; p_stop = clk_stop_o; p_done = done_o;
    end
  end

  // watchdog
  initial begin
    repeat (20000) @(posedge clk_i);
    if (!finished) begin
      check(0, "watchdog", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    // R10: reset state
    check(mac_rst_o == 2'b00, "R10 rst", mac_rst_o, 0);
    check(clk_stop_o == 2'b11, "R10 stop", clk_stop_o, 3);
    check(div_field_o == 0, "R10 field", div_field_o, 0);
    check({busy_o, unlock_o, done_o, err_o} == 4'b0, "R10 flags",
          {busy_o, unlock_o, done_o, err_o}, 0);
    rst_ni = 1;
    repeat (2) @(negedge clk_i);
    bringup(1, 2'b00, 400, 1);   // 16, field 7; mid-run request for MAC 2 dropped
    bringup(2, 2'b01, 400, 0);   // 4, field 1
    bad_index(0);
    bringup(1, 2'b10, 250, 0);   // 2 -> clamp 4
    bringup(2, 2'b00, 1000, 0);  // 40 -> clamp 16
    bad_index(3);
    bringup(1, 2'b00, 230, 0);   // 9 -> field 3
    bringup(2, 2'b11, 700, 0);   // 7 -> field 2
    repeat (4) @(negedge clk_i);
    check(sb.size() == 0, "R6 scoreboard drained", sb.size(), 0);
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule